// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor with one accumulator. Code and data sit in one memory that it reaches through a single synchronous port. Every instruction moves through explicit register transfers. The program counter is copied into the memory address register. The word read back is captured in the memory data register and then moved into the current instruction register. Decode looks only at that instruction register. A direct operand costs a second trip through the address and data registers. Execute then updates the accumulator, writes memory or redirects the program counter.

The core is meant for small sequencing jobs inside a larger chip. A memory model or a RAM macro wrapper sits on the port. Arithmetic results stay in the accumulator until a store instruction writes them out. A halt instruction parks the core, and it stays parked until reset.

Top module: `acc_core`

## Requirements
- R1: An instruction word is 16 bits: bits [15:12] hold the opcode, bit [11] is set for an immediate operand and clear for a direct (memory) operand, and bits [10:0] hold the operand or address. Opcodes: 1 load, 2 store, 3 add, 4 subtract, 5 jump, 6 jump-if-zero, 7 halt, 0 no-op.
- R2: One memory access is outstanding at a time, and read data arrives one cycle after the address. An instruction with no direct operand takes 6 cycles. A direct load, add or subtract takes 8 cycles.
- R3: An immediate operand is zero-extended to 16 bits. Add and subtract update the accumulator modulo 2^16, and load replaces it.
- R4: A direct operand is the 16-bit word read from the address in bits [10:0], in the same memory that holds the program.
- R5: A store writes the accumulator to the address in bits [10:0] with exactly one write strobe. No other instruction drives a memory write.
- R6: A jump sets the next fetch address to bits [10:0]. A jump-if-zero does so only when all 16 accumulator bits are zero; otherwise execution continues with the next word.
- R7: Opcodes 0 and 8 to 15 change neither the accumulator nor memory. Execution continues with the next word.
- R8: After a halt, `halted` is high and stays high. No further write strobe appears, and no later instruction runs, until reset.
- R9: During reset `halted` and `mem_we` are low and `mem_addr` is 0. The first fetch after reset reads address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 11 | Address of the current memory access |
| mem_wdata | output | 16 | Data to be written (accumulator) |
| mem_we | output | 1 | Write strobe for one cycle |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt has executed |

## Verification
Any wrong register transfer shows up quickly at the ports. A bad program counter or address register shifts the fetch stream, so stored results land at the wrong address or the halt cycle moves. A program that runs to halt therefore reveals it within one instruction time of 6 to 8 cycles. An accumulator error or a mistaken jump decision appears in the next stored word. An operand-path error appears in the value stored after a direct read. A broken halt shows up as a late write to a guard word or as `halted` dropping within the cycles after the halt.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OP_NOP   = 4'd0;
   localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
   localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
   localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
   localparam logic [OPC_W-1:0] OP_SUB   = 4'd4;
   localparam logic [OPC_W-1:0] OP_JUMP  = 4'd5;
   localparam logic [OPC_W-1:0] OP_JZERO = 4'd6;
   localparam logic [OPC_W-1:0] OP_HALT  = 4'd7;

   typedef enum logic [3:0] {
      ST_F_ADDR  = 4'd0,
      ST_F_READ  = 4'd1,
      ST_F_LATCH = 4'd2,
      ST_F_IR    = 4'd3,
      ST_DECODE  = 4'd4,
      ST_O_READ  = 4'd5,
      ST_O_LATCH = 4'd6,
      ST_EXEC    = 4'd7,
      ST_HALT    = 4'd8
   } phase_e;

   typedef struct packed {
      logic mar_pc;
      logic mar_opnd;
      logic pc_inc;
      logic pc_jmp;
      logic mdr_ld;
      logic cir_ld;
      logic acc_ld;
      logic mem_we;
   } ctl_t;

   function automatic logic is_arith(input logic [OPC_W-1:0] op);
      return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB);
   endfunction

   function automatic logic wants_mem_operand(input logic [OPC_W-1:0] op, input logic imm);
      return is_arith(op) && !imm;
   endfunction

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_core_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] op,
   input  logic             imm,
   input  logic             acc_zero,
   output phase_e           phase,
   output ctl_t             ctl
);

   phase_e phase_nx;

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         ST_F_ADDR:  phase_nx = ST_F_READ;
         ST_F_READ:  phase_nx = ST_F_LATCH;
         ST_F_LATCH: phase_nx = ST_F_IR;
         ST_F_IR:    phase_nx = ST_DECODE;
         ST_DECODE:  phase_nx = wants_mem_operand(op, imm) ? ST_O_READ : ST_EXEC;
         ST_O_READ:  phase_nx = ST_O_LATCH;
         ST_O_LATCH: phase_nx = ST_EXEC;
         ST_EXEC:    phase_nx = (op == OP_HALT) ? ST_HALT : ST_F_ADDR;
         ST_HALT:    phase_nx = ST_HALT;
         default:    phase_nx = ST_F_ADDR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= ST_F_ADDR;
      else        phase <= phase_nx;
   end

   always_comb begin
      ctl          = '0;
      ctl.mar_pc   = (phase == ST_F_ADDR);
      ctl.pc_inc   = (phase == ST_F_READ);
      ctl.mdr_ld   = (phase == ST_F_LATCH) || (phase == ST_O_LATCH);
      ctl.cir_ld   = (phase == ST_F_IR);
      ctl.mar_opnd = (phase == ST_DECODE) && (wants_mem_operand(op, imm) || (op == OP_STORE));
      ctl.acc_ld   = (phase == ST_EXEC) && is_arith(op);
      ctl.pc_jmp   = (phase == ST_EXEC) && ((op == OP_JUMP) || ((op == OP_JZERO) && acc_zero));
      ctl.mem_we   = (phase == ST_EXEC) && (op == OP_STORE);
   end

   AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) ctl.mem_we |=> !ctl.mem_we); // R5
   AST_JUMP_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n) ctl.pc_jmp |=> (phase == ST_F_ADDR)); // R6

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_core_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 11,
   parameter bit IMM_SIGNED = 1'b0
)(
   input  logic [OPC_W-1:0]  op,
   input  logic              imm,
   input  logic [ADDR_W-1:0] field,
   input  logic [DATA_W-1:0] mdr,
   input  logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] result
);

   localparam int EXT_W = DATA_W - ADDR_W;

   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] operand;

   generate
      if (IMM_SIGNED) begin : g_sext
         assign imm_ext = {{EXT_W{field[ADDR_W-1]}}, field};
      end else begin : g_zext
         assign imm_ext = {{EXT_W{1'b0}}, field};
      end
   endgenerate

   assign operand = imm ? imm_ext : mdr;

   always_comb begin
      result = acc;
      case (op)
         OP_LOAD: result = operand;
         OP_ADD:  result = acc + operand;
         OP_SUB:  result = acc - operand;
         default: result = acc;
      endcase
   end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
   import acc_core_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 11,
   parameter bit IMM_SIGNED = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl,
   input  phase_e            phase,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [OPC_W-1:0]  op,
   output logic              imm,
   output logic              acc_zero
);

   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] mar;
   logic [DATA_W-1:0] mdr;
   logic [DATA_W-1:0] cir;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] alu_res;
   logic [ADDR_W-1:0] field;
   logic [ADDR_W-1:0] mar_plus;

   assign op       = cir[DATA_W-1 -: OPC_W];
   assign imm      = cir[ADDR_W];
   assign field    = cir[ADDR_W-1:0];
   assign acc_zero = (acc == '0);
   assign mem_addr = mar;
   assign mem_wdata = acc;
   assign mar_plus = mar + 1'b1;

   acc_alu #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .IMM_SIGNED (IMM_SIGNED)
   ) u_alu (
      .op     (op),
      .imm    (imm),
      .field  (field),
      .mdr    (mdr),
      .acc    (acc),
      .result (alu_res)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc  <= '0;
         mar <= '0;
         mdr <= '0;
         cir <= '0;
         acc <= '0;
      end else begin
         if (ctl.mar_pc)        mar <= pc;
         else if (ctl.mar_opnd) mar <= field;
         if (ctl.pc_jmp)        pc  <= field;
         else if (ctl.pc_inc)   pc  <= pc + 1'b1;
         if (ctl.mdr_ld)        mdr <= mem_rdata;
         if (ctl.cir_ld)        cir <= mdr;
         if (ctl.acc_ld)        acc <= alu_res;
      end
   end

   AST_FETCH_PC_AHEAD: assert property (@(posedge clk) disable iff (!rst_n) (phase == ST_F_IR) |-> (pc == mar_plus)); // R2
   AST_STORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n) ctl.mem_we |-> (mar == field)); // R5
   AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (phase != ST_EXEC) |=> $stable(acc)); // R3
   AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (phase == ST_HALT) |=> ($stable(pc) && $stable(acc))); // R8

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 11,
   parameter bit IMM_SIGNED = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted
);

   generate
      if (DATA_W != OPC_W + 1 + ADDR_W) begin : g_bad_format
         $error("acc_core: DATA_W must equal opcode width + 1 + ADDR_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("acc_core: ADDR_W must be at least 2");
      end
   endgenerate

   phase_e           phase;
   ctl_t             ctl;
   logic [OPC_W-1:0] op;
   logic             imm;
   logic             acc_zero;

   acc_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .imm      (imm),
      .acc_zero (acc_zero),
      .phase    (phase),
      .ctl      (ctl)
   );

   acc_datapath #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .IMM_SIGNED (IMM_SIGNED)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .phase     (phase),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .op        (op),
      .imm       (imm),
      .acc_zero  (acc_zero)
   );

   assign mem_we = ctl.mem_we;
   assign halted = (phase == ST_HALT);

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R8
   AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !mem_we); // R8

endmodule

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;

   localparam int DW = 16;
   localparam int AW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we;
   logic [DW-1:0] mem_rdata = '0;
   logic          halted;

   logic [DW-1:0] mem [0:255];
   int            wr_count;
   int            checks = 0;
   int            errors = 0;

   always #10 clk = ~clk;

   acc_core u_acc_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .halted    (halted)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
      if (!rst_n)      wr_count <= 0;
      else if (mem_we) wr_count <= wr_count + 1;
   end

   function automatic logic [15:0] enc(input int op, input int im, input int opnd);
      return {op[3:0], im[0], opnd[10:0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_case(input int a, input int b, input int d);
      int cyc;
      int exp_cyc;
      bit stay;
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
      @(negedge clk);
      mem[0]   <= enc(1, 1, a);
      mem[1]   <= enc(3, 1, b);
      mem[2]   <= enc(11, 1, 2047);
      mem[3]   <= enc(2, 0, 100);
      mem[4]   <= enc(4, 0, 200);
      mem[5]   <= enc(2, 0, 101);
      mem[6]   <= enc(1, 0, 200);
      mem[7]   <= enc(3, 0, 200);
      mem[8]   <= enc(2, 0, 102);
      mem[9]   <= enc(1, 1, a);
      mem[10]  <= enc(4, 1, b);
      mem[11]  <= enc(6, 0, 14);
      mem[12]  <= enc(1, 1, 1);
      mem[13]  <= enc(5, 0, 15);
      mem[14]  <= enc(1, 1, 2);
      mem[15]  <= enc(2, 0, 103);
      mem[16]  <= enc(7, 0, 0);
      mem[17]  <= enc(2, 0, 104);
      mem[104] <= 16'hBEEF;
      mem[200] <= d[15:0];
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R9 reset state
      chk(!halted && !mem_we && (mem_addr == '0), "R9 reset outputs",
          {halted, mem_we, 16'(mem_addr)}, 0);
      rst_n = 1'b1;
      cyc = 0;
      while (!halted && cyc < 400) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      exp_cyc = (a == b) ? 96 : 102;
      chk(cyc == exp_cyc, "R2 R6 cycles to halt", cyc, exp_cyc);
      chk(mem[100] == 16'(a + b), "R3 R7 immediate sum stored", mem[100], 16'(a + b));
      chk(mem[101] == 16'(a + b - d), "R4 direct subtract", mem[101], 16'(a + b - d));
      chk(mem[102] == 16'(2 * d), "R1 R4 direct load and add", mem[102], 16'(2 * d));
      chk(mem[103] == ((a == b) ? 16'd2 : 16'd1), "R6 jump-if-zero path",
          mem[103], (a == b) ? 2 : 1);
      stay = 1'b1;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (!halted || mem_we) stay = 1'b0;
      end
      chk(stay, "R8 halt held", stay, 1);
      chk(mem[104] == 16'hBEEF, "R8 no instruction after halt", mem[104], 16'hBEEF);
      chk(wr_count == 4, "R5 one write per store", wr_count, 4);
      chk(mem[2] == enc(11, 1, 2047), "R7 undefined opcode leaves memory", mem[2], enc(11, 1, 2047));
   endtask

   initial begin : wd
      #3_800_000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", checks);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int ai = 0; ai <= 16; ai++) begin
         for (int bi = 0; bi <= 16; bi++) begin
            int a;
            int b;
            int d;
            a = (ai == 16) ? 2047 : ai * 131;
            b = (bi == 16) ? 2047 : bi * 131;
            d = (a * 97 + b * 13 + 61455) & 16'hFFFF;
            run_case(a, b, d);
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule